// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It takes the command pins (chip select, row strobe, column strobe, write enable and clock enable) and uses them to put the memory into self-refresh and bring it back out. A host raises `sleep_req`. The sequencer may first issue a burst of auto-refresh commands. It then issues the self-refresh entry command and keeps the clock enable low for as long as the host holds the request. After that it runs the exit sequence and hands the command bus back.

The exit follows a fixed order. First the device stays in self-refresh for a minimum residency time. Next, the clock-enable pin stays low for a clock-stable wait, so the memory clock can settle. Then the clock enable rises with the chip deselected, and a recovery window runs before any command may follow. When `burst_en` is high at the moment the request is accepted, a burst of auto-refresh commands is issued both before entry and after recovery. Each burst is `AREF_COUNT` commands, one every `T_RFC` cycles.

The host sees a four-phase handshake:
- `sleep_ack` rises only once the device is in self-refresh.
- `sleep_ack` falls in the same cycle that `bus_busy` drops, which marks the bus as released.

Top module: `sdram_sr_seq`

## Requirements
- R1: After synchronous reset, and whenever the sequencer is idle, `sdr_cke`=1, `sdr_cs_n`=1, `sleep_ack`=0 and `bus_busy`=0.
- R2: When a request is accepted with bursts off, the very next cycle carries the entry command: `sdr_cke`, `sdr_cs_n`, `sdr_ras_n` and `sdr_cas_n` all 0 and `sdr_we_n`=1. A falling `sdr_cke` always coincides with this pattern.
- R3: `sleep_ack` rises exactly one cycle after the entry cycle, and only while `sdr_cke` is low.
- R4: In every cycle with `sdr_cke` low other than the entry cycle, `sdr_cs_n` is 1.
- R5: Once the request is released, exit starts only when at least `T_RAS` cycles have passed since the entry cycle. If the request is still high after `T_RAS`, self-refresh lasts until the first cycle in which the request is seen low.
- R6: From the start of exit, `sdr_cke` stays low for a further `T_CKS` cycles (clock-stable wait). The total low time of `sdr_cke` is therefore 1 + max(`T_RAS`, hold+1) + `T_CKS` cycles, where hold is the number of cycles the request stays high after `sleep_ack` rises.
- R7: After `sdr_cke` rises, `sdr_cs_n` stays 1 for `T_RC` cycles before any command is issued, and `sleep_ack` stays 1 throughout that window.
- R8: With bursts on, `AREF_COUNT` auto-refresh commands are issued before entry and again after recovery. An auto-refresh command is `sdr_cke`=1, `sdr_cs_n`=0, `sdr_ras_n`=0, `sdr_cas_n`=0, `sdr_we_n`=1.
  - Within a burst, consecutive commands are `T_RFC` cycles apart.
  - The last pre-entry command is `T_RFC` cycles before the entry command.
  - The first post-exit command comes right after the recovery window.
- R9: `burst_en` is sampled only when a request is accepted. Later changes to it have no effect on the sequence in progress.
- R10: `sleep_ack` and `bus_busy` fall in the same cycle. That cycle is either `T_RFC` cycles after the last post-exit auto-refresh, or, with bursts off, the cycle right after the recovery window.
- R11: `bus_busy` is 1 from the first command cycle after acceptance until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Host request to enter and stay in self-refresh |
| burst_en | input | 1 | Selects auto-refresh bursts around the sleep period; sampled at acceptance |
| sleep_ack | output | 1 | High while the device is in, or recovering from, self-refresh |
| bus_busy | output | 1 | High while the sequencer owns the command pins |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cs_n | output | 1 | SDRAM chip select, active low |
| sdr_ras_n | output | 1 | SDRAM row strobe, active low |
| sdr_cas_n | output | 1 | SDRAM column strobe, active low |
| sdr_we_n | output | 1 | SDRAM write enable, active low |

## Verification
The assertions check local pin rules on every cycle:
- a falling clock enable only ever comes with the entry command;
- the chip stays deselected while the clock enable is low, and for `T_RC` cycles after it rises;
- each low period of the clock enable lasts at least `T_RAS`+`T_CKS`+1 cycles;
- the acknowledge rises only in self-refresh and falls only together with `bus_busy`.

Other properties need whole-transaction scenarios swept over burst mode and request hold time:
- the exact auto-refresh counts and spacing;
- the cycle in which exit begins for each hold time;
- that a late change of `burst_en` is ignored;
- the exact completion cycle.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AREF,
        ST_AGAP,
        ST_ENTER,
        ST_HOLD,
        ST_CLKW,
        ST_RECOV
    } sr_state_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sr_pins_t;

    localparam sr_pins_t PINS_DESEL = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sr_pins_t PINS_NOP   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sr_pins_t PINS_AREF  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sr_pins_t PINS_SRE   = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sr_pins_t PINS_SLEEP = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic sr_pins_t sr_decode(sr_state_e s);
        case (s)
            ST_AREF:  return PINS_AREF;
            ST_AGAP:  return PINS_NOP;
            ST_ENTER: return PINS_SRE;
            ST_HOLD:  return PINS_SLEEP;
            ST_CLKW:  return PINS_SLEEP;
            default:  return PINS_DESEL;
        endcase
    endfunction

    function automatic int unsigned sr_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/sr_cmd_drive.sv
module sr_cmd_drive
    import sr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sr_state_e state,
    output sr_pins_t  pins
);
    always_comb pins = sr_decode(state);

    // R4
    sleep_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!pins.cke && !pins.cs_n) |-> (!pins.ras_n && !pins.cas_n && pins.we_n));

endmodule

// File: rtl/sdram_sr_seq.sv
module sdram_sr_seq
    import sr_seq_pkg::*;
#(
    parameter int T_RAS      = 6,
    parameter int T_CKS      = 4,
    parameter int T_RC       = 8,
    parameter int T_RFC      = 10,
    parameter int AREF_COUNT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic burst_en,
    output logic sleep_ack,
    output logic bus_busy,
    output logic sdr_cke,
    output logic sdr_cs_n,
    output logic sdr_ras_n,
    output logic sdr_cas_n,
    output logic sdr_we_n
);
    localparam int TMAX     = sr_max(sr_max(T_RAS, T_CKS), sr_max(T_RC, T_RFC));
    localparam int TW       = $clog2(TMAX + 1);
    localparam int RW       = $clog2(AREF_COUNT + 1);
    localparam int LOW_SAT  = T_RAS + T_CKS + 1;
    localparam int LW       = $clog2(LOW_SAT + 1);
    localparam int HW       = $clog2(T_RC + 1);

    sr_state_e state_q, state_d;
    logic      ack_q, burst_q, side_q;
    logic      t_load, t_zero, r_load, r_zero;
    logic [TW-1:0] t_val;
    sr_pins_t  pins;

    sr_timer #(.W(TW)) u_wait (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .dec(1'b1), .zero(t_zero)
    );

    sr_timer #(.W(RW)) u_refs (
        .clk(clk), .rst(rst), .load(r_load), .load_val(RW'(AREF_COUNT)),
        .dec(state_q == ST_AREF), .zero(r_zero)
    );

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        r_load  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    if (burst_en) begin
                        state_d = ST_AREF;
                        r_load  = 1'b1;
                    end else begin
                        state_d = ST_ENTER;
                    end
                end
            end
            ST_AREF: begin
                state_d = ST_AGAP;
                t_load  = 1'b1;
                t_val   = TW'(T_RFC - 2);
            end
            ST_AGAP: begin
                if (t_zero) begin
                    if (!r_zero)
                        state_d = ST_AREF;
                    else if (side_q)
                        state_d = ST_IDLE;
                    else
                        state_d = ST_ENTER;
                end
            end
            ST_ENTER: begin
                state_d = ST_HOLD;
                t_load  = 1'b1;
                t_val   = TW'(T_RAS - 1);
            end
            ST_HOLD: begin
                if (t_zero && !sleep_req) begin
                    state_d = ST_CLKW;
                    t_load  = 1'b1;
                    t_val   = TW'(T_CKS - 1);
                end
            end
            ST_CLKW: begin
                if (t_zero) begin
                    state_d = ST_RECOV;
                    t_load  = 1'b1;
                    t_val   = TW'(T_RC - 1);
                end
            end
            ST_RECOV: begin
                if (t_zero) begin
                    if (burst_q) begin
                        state_d = ST_AREF;
                        r_load  = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            burst_q <= 1'b0;
            side_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && sleep_req) begin
                burst_q <= burst_en;
                side_q  <= 1'b0;
            end
            if (state_q == ST_RECOV && state_d == ST_AREF)
                side_q <= 1'b1;
            if (state_d == ST_HOLD)
                ack_q <= 1'b1;
            else if (state_d == ST_IDLE)
                ack_q <= 1'b0;
        end
    end

    sr_cmd_drive u_drive (
        .clk(clk), .rst(rst), .state(state_q), .pins(pins)
    );

    assign sdr_cke   = pins.cke;
    assign sdr_cs_n  = pins.cs_n;
    assign sdr_ras_n = pins.ras_n;
    assign sdr_cas_n = pins.cas_n;
    assign sdr_we_n  = pins.we_n;
    assign sleep_ack = ack_q;
    assign bus_busy  = (state_q != ST_IDLE);

    // Pin-history counters used only by the checks below
    logic [LW-1:0] low_cnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hi_cnt  <= HW'(T_RC);
        end else begin
            if (sdr_cke)
                low_cnt <= '0;
            else if (low_cnt != LW'(LOW_SAT))
                low_cnt <= low_cnt + 1'b1;
            if (!sdr_cke)
                hi_cnt <= '0;
            else if (hi_cnt != HW'(T_RC))
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R2
    cke_fall_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sdr_cke) |-> (!sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n));

    // R3
    ack_rise_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_ack) |-> !sdr_cke);

    // R6
    min_low_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdr_cke) |-> (low_cnt >= LW'(LOW_SAT)));

    // R7
    recovery_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (sdr_cke && (hi_cnt < HW'(T_RC))) |-> sdr_cs_n);

    // R10
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_ack) |-> !bus_busy);

endmodule

// File: tb/sdram_sr_seq_bench.sv
module sdram_sr_seq_bench;
    localparam int T_RAS = 4;
    localparam int T_CKS = 2;
    localparam int T_RC  = 3;
    localparam int T_RFC = 3;
    localparam int NREF  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic burst_en = 1'b0;
    logic sleep_ack, bus_busy, sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;

    int vectors = 0;
    int misses  = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    sdram_sr_seq #(
        .T_RAS(T_RAS), .T_CKS(T_CKS), .T_RC(T_RC), .T_RFC(T_RFC), .AREF_COUNT(NREF)
    ) u_sdram_sr_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .burst_en(burst_en),
        .sleep_ack(sleep_ack), .bus_busy(bus_busy), .sdr_cke(sdr_cke),
        .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
        .sdr_we_n(sdr_we_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    task automatic check_idle(input string tag);
        check(sdr_cke && sdr_cs_n, {tag, " R1 idle pins"}, {sdr_cke, sdr_cs_n}, 3);
        check(!sleep_ack && !bus_busy, {tag, " R1 idle ack/busy"}, {sleep_ack, bus_busy}, 0);
    endtask

    task automatic run_case(input bit b, input int h);
        int cyc = 0, first_cmd = -1, sre_idx = -1, ack_rise = -1, cke_rise = -1;
        int idle_idx = -1, first_post = -1, n_pre = 0, n_post = 0, last_aref = -1;
        int pre_to_sre = -1, gap_err = 0, cs_err = 0, rec_err = 0, ack_err = 0;
        int low_len = 0, ack_at_idle = 0;
        int exp_sre, exp_low, exp_rise, exp_post, exp_idle;
        bit done = 0, dropped = 0, is_aref, is_sre;
        @(negedge clk);
        sleep_req = 1'b1;
        burst_en  = b;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            is_aref = sdr_cke && !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n;
            is_sre  = !sdr_cke && !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n;
            if (first_cmd < 0 && bus_busy) first_cmd = cyc;
            if (is_aref) begin
                if (last_aref >= 0 && (cyc - last_aref) != T_RFC) gap_err++;
                if (sre_idx < 0) n_pre++;
                else begin
                    n_post++;
                    if (first_post < 0) first_post = cyc;
                end
                last_aref = cyc;
            end
            if (is_sre && sre_idx < 0) begin
                sre_idx = cyc;
                if (last_aref >= 0) pre_to_sre = cyc - last_aref;
                last_aref = -1;
            end
            if (sre_idx >= 0 && cke_rise < 0) begin
                if (!sdr_cke) begin
                    low_len++;
                    if (cyc != sre_idx && !sdr_cs_n) cs_err++;
                end else begin
                    cke_rise = cyc;
                end
            end
            if (cke_rise >= 0 && cyc < cke_rise + T_RC && !sdr_cs_n) rec_err++;
            if (sleep_ack && ack_rise < 0) ack_rise = cyc;
            if (ack_rise >= 0 && bus_busy && !sleep_ack) ack_err++;
            if (!bus_busy) begin
                idle_idx    = cyc;
                ack_at_idle = sleep_ack;
                done        = 1;
            end
            if (ack_rise >= 0 && !dropped && cyc == ack_rise + h) begin
                sleep_req = 1'b0;
                burst_en  = !b;
                dropped   = 1;
            end
        end

        exp_sre  = b ? 1 + NREF * T_RFC : 1;
        exp_low  = 1 + ((T_RAS > h + 1) ? T_RAS : h + 1) + T_CKS;
        exp_rise = exp_sre + exp_low;
        exp_post = exp_rise + T_RC;
        exp_idle = b ? exp_post + NREF * T_RFC : exp_rise + T_RC;

        check(first_cmd == 1, "R11 busy from first command", first_cmd, 1);
        check(n_pre == (b ? NREF : 0), "R8 pre-entry refresh count", n_pre, b ? NREF : 0);
        check(sre_idx == exp_sre, "R2 entry command cycle", sre_idx, exp_sre);
        if (b) check(pre_to_sre == T_RFC, "R8 last refresh to entry", pre_to_sre, T_RFC);
        check(ack_rise == exp_sre + 1, "R3 ack rise cycle", ack_rise, exp_sre + 1);
        check(low_len == exp_low, "R5 R6 cke low length", low_len, exp_low);
        check(cke_rise == exp_rise, "R6 cke rise cycle", cke_rise, exp_rise);
        check(cs_err == 0, "R4 deselect while asleep", cs_err, 0);
        check(rec_err == 0, "R7 deselect during recovery", rec_err, 0);
        check(ack_err == 0, "R7 ack held until release", ack_err, 0);
        check(n_post == (b ? NREF : 0), "R9 post-exit refresh count follows sampled mode",
              n_post, b ? NREF : 0);
        if (b) check(first_post == exp_post, "R8 first post-exit refresh", first_post, exp_post);
        check(gap_err == 0, "R8 refresh spacing", gap_err, 0);
        check(idle_idx == exp_idle, "R10 completion cycle", idle_idx, exp_idle);
        check(ack_at_idle == 0, "R10 ack low with busy low", ack_at_idle, 0);

        burst_en = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("after case");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("in reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("after reset");
        for (int b = 0; b < 2; b++) begin
            for (int h = 0; h <= T_RAS + 3; h++) begin
                run_case(b[0], h);
            end
        end
        finish_run();
    end

endmodule